// File: doc/BRIEF.md
# Filtered Power-Fail Interrupt Pulser

This block sits behind an early-warning supply comparator and turns its synchronous "below threshold" flag into an active-low non-maskable interrupt. The flag is treated as a real power-fail warning only after it has stayed high for a programmable number of consecutive clock cycles. Brief excursions caused by supply noise therefore never reach the processor. Once a warning qualifies, the interrupt output is driven low for a programmable minimum number of cycles.

A second input, the supply-good flag, gates the whole function. While that flag is low, for example during power-up before the local rail has settled, the block ignores the comparator, holds its qualification state cleared and keeps the interrupt output inactive. Each qualified event produces exactly one pulse. A further pulse needs the warning flag to drop and then qualify again. A build-time option selects whether a warning that requalifies while a pulse is still running is absorbed or restarts the pulse at full width.

Top module: `pfail_nmi_pulser`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `nmi_no` is high (inactive), whatever the other inputs are.
- R2: With `supply_ok_i` high, `nmi_no` goes low at the rising edge that samples `below_i` high for the QUAL_CYC-th consecutive time. If `below_i` is first sampled at edge 1, the output is low from edge QUAL_CYC onward.
- R3: A run of fewer than QUAL_CYC consecutive high samples of `below_i` produces no pulse. One low sample restarts the count from zero, so two short runs never add up.
- R4: With the absorb option (REARM = REARM_ABSORB, the default), every pulse keeps `nmi_no` low for exactly PULSE_CYC cycles while `supply_ok_i` stays high.
- R5: One pulse is produced per qualified event. Holding `below_i` high for any time past qualification does not produce a second pulse. A new pulse needs `below_i` to be sampled low and then to qualify again.
- R6: While `supply_ok_i` is low, `nmi_no` is high in the same cycle and `below_i` has no effect. A pulse that is running when `supply_ok_i` falls is ended, and the qualification count is held at zero.
- R7: Qualification starts at the first edge that samples `supply_ok_i` high, even when `below_i` was already high before that. A low `supply_ok_i` clears the one-pulse-per-event lock, so a warning that persists across a supply-good dropout produces a fresh pulse.
- R8: When `below_i` requalifies while a pulse is still running, the absorb option leaves the running pulse unchanged and adds no pulse. The restart option (REARM = REARM_RESTART) reloads the pulse so that it ends PULSE_CYC cycles after the requalifying edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| below_i | input | 1 | Synchronous flag from the early-warning comparator, high while the sensed supply is below its trip point |
| supply_ok_i | input | 1 | Synchronous supply-good flag, high once the local rail is valid; enables the block |
| nmi_no | output | 1 | Non-maskable interrupt, active low |

## Verification
The bound checker assumes that `below_i` and `supply_ok_i` are synchronous to `clk_i` and stable around its rising edge. It also assumes that they change only as whole-cycle levels, so that its own run and width counters see the same samples as the design. The bench meets this by changing every input one nanosecond after a rising edge and reading the output on the falling edge. It sweeps the warning run length across the qualification boundary, splits runs with single-cycle gaps, and toggles the supply-good flag before, during and after pulses. It does all of this on two small instances that differ only in the requalification option.

// File: rtl/pfi_pkg.sv
`timescale 1ns/1ps
package pfi_pkg;

   // Counter width able to hold the values 0 .. n-1 (at least one bit).
   function automatic int cnt_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // Policy for a warning that requalifies while a pulse is still running.
   typedef enum logic {
      REARM_ABSORB  = 1'b0,
      REARM_RESTART = 1'b1
   } rearm_e;

endpackage

// File: rtl/pfi_qualifier.sv
`timescale 1ns/1ps
// Counts consecutive enabled cycles of the warning level and flags the
// cycle in which the run reaches its required length (and every later
// cycle of the same run).
module pfi_qualifier #(
   parameter int QUAL_CYC = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic level_i,
   output logic hit_o
);
   localparam int QW = pfi_pkg::cnt_bits(QUAL_CYC);
   localparam logic [QW-1:0] RUN_LAST = QW'(QUAL_CYC - 1);

   logic          live;
   logic [QW-1:0] run_q;

   assign live = arm_i & level_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q <= '0;
      end else if (!live) begin
         run_q <= '0;
      end else if (run_q != RUN_LAST) begin
         run_q <= run_q + 1'b1;
      end
   end

   assign hit_o = live & (run_q == RUN_LAST);
endmodule

// File: rtl/pfi_event_gate.sv
`timescale 1ns/1ps
// Passes only the first qualifying cycle of each warning event. The lock
// releases when the warning level drops or the block is disarmed.
module pfi_event_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic level_i,
   input  logic hit_i,
   output logic fire_o
);
   logic spent_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         spent_q <= 1'b0;
      end else if (!level_i || !arm_i) begin
         spent_q <= 1'b0;
      end else if (hit_i) begin
         spent_q <= 1'b1;
      end
   end

   assign fire_o = hit_i & ~spent_q;
endmodule

// File: rtl/pfi_pulse_timer.sv
`timescale 1ns/1ps
// Holds busy_o high for PULSE_CYC cycles after a load. The REARM policy
// selects whether a load during an active pulse is dropped or restarts it.
module pfi_pulse_timer #(
   parameter int             PULSE_CYC = 40000,
   parameter pfi_pkg::rearm_e REARM    = pfi_pkg::REARM_ABSORB
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic fire_i,
   output logic busy_o
);
   localparam int PW = pfi_pkg::cnt_bits(PULSE_CYC);
   localparam logic [PW-1:0] CNT_LAST = PW'(PULSE_CYC - 1);

   logic          busy_q;
   logic          load;
   logic [PW-1:0] cnt_q;

   generate
      if (REARM == pfi_pkg::REARM_RESTART) begin : g_restart
         assign load = fire_i;
      end else begin : g_absorb
         assign load = fire_i & ~busy_q;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!arm_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == CNT_LAST) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
endmodule

// File: rtl/pfail_nmi_pulser.sv
`timescale 1ns/1ps
module pfail_nmi_pulser #(
   parameter int              QUAL_CYC  = 1000,
   parameter int              PULSE_CYC = 40000,
   parameter pfi_pkg::rearm_e REARM     = pfi_pkg::REARM_ABSORB
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic below_i,
   input  logic supply_ok_i,
   output logic nmi_no
);
   generate
      if (QUAL_CYC < 1) begin : g_bad_qual
         $error("pfail_nmi_pulser: QUAL_CYC must be at least 1");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("pfail_nmi_pulser: PULSE_CYC must be at least 1");
      end
   endgenerate

   logic hit;
   logic fire;
   logic busy;

   pfi_qualifier #(
      .QUAL_CYC (QUAL_CYC)
   ) u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .arm_i   (supply_ok_i),
      .level_i (below_i),
      .hit_o   (hit)
   );

   pfi_event_gate u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .arm_i   (supply_ok_i),
      .level_i (below_i),
      .hit_i   (hit),
      .fire_o  (fire)
   );

   pfi_pulse_timer #(
      .PULSE_CYC (PULSE_CYC),
      .REARM     (REARM)
   ) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .arm_i   (supply_ok_i),
      .fire_i  (fire),
      .busy_o  (busy)
   );

   // Supply-good gates the output directly so it is inactive in the same cycle.
   assign nmi_no = ~(busy & supply_ok_i);
endmodule

// File: rtl/pfail_nmi_pulser_chk.sv
`timescale 1ns/1ps
module pfail_nmi_pulser_chk #(
   parameter int              QUAL_CYC  = 1000,
   parameter int              PULSE_CYC = 40000,
   parameter pfi_pkg::rearm_e REARM     = pfi_pkg::REARM_ABSORB
) (
   input logic clk_i,
   input logic rst_ni,
   input logic below_i,
   input logic supply_ok_i,
   input logic nmi_no,
   input logic busy
);
   int  run_len;
   int  low_len;
   logic fired;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_len <= 0;
         low_len <= 0;
         fired   <= 1'b0;
      end else begin
         if (below_i && supply_ok_i) begin
            run_len <= (run_len < QUAL_CYC) ? run_len + 1 : run_len;
         end else begin
            run_len <= 0;
         end
         if (!nmi_no) begin
            low_len <= (low_len < PULSE_CYC * 4) ? low_len + 1 : low_len;
         end else begin
            low_len <= 0;
         end
         if (!below_i || !supply_ok_i) begin
            fired <= 1'b0;
         end else if (!nmi_no) begin
            fired <= 1'b1;
         end
      end
   end

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> nmi_no);                                        // R1
   AST_QUALIFIED_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(nmi_no) |-> run_len == QUAL_CYC);                            // R2
   AST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(nmi_no) && supply_ok_i) |-> low_len >= PULSE_CYC);          // R4
   AST_MAX_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((REARM == pfi_pkg::REARM_ABSORB) && !nmi_no) |-> low_len < PULSE_CYC); // R4
   AST_ONE_PER_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(nmi_no) |-> !fired);                                         // R5
   AST_GATED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !supply_ok_i |=> !busy);                                           // R6
endmodule

bind pfail_nmi_pulser pfail_nmi_pulser_chk #(
   .QUAL_CYC  (QUAL_CYC),
   .PULSE_CYC (PULSE_CYC),
   .REARM     (REARM)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .below_i     (below_i),
   .supply_ok_i (supply_ok_i),
   .nmi_no      (nmi_no),
   .busy        (busy)
);

// File: tb/pfail_nmi_pulser_test.sv
`timescale 1ns/1ps
module pfail_nmi_pulser_test;
   localparam int Q = 4;
   localparam int P = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic below = 1'b0;
   logic ok = 1'b0;
   logic nmi_a, nmi_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pfail_nmi_pulser #(.QUAL_CYC(Q), .PULSE_CYC(P), .REARM(pfi_pkg::REARM_ABSORB)) uut (
      .clk_i(clk), .rst_ni(rst_n), .below_i(below), .supply_ok_i(ok), .nmi_no(nmi_a));
   pfail_nmi_pulser #(.QUAL_CYC(Q), .PULSE_CYC(P), .REARM(pfi_pkg::REARM_RESTART)) uut_rt (
      .clk_i(clk), .rst_ni(rst_n), .below_i(below), .supply_ok_i(ok), .nmi_no(nmi_b));

   // Falling-edge monitor: sample index, low cycles, first low index, falls.
   bit mon_on = 1'b0;
   int smp;
   int a_low, a_first, a_falls;
   int b_low, b_first, b_falls;
   logic a_prev, b_prev;

   always @(negedge clk) begin
      if (mon_on) begin
         smp++;
         if (!nmi_a) begin
            a_low++;
            if (a_first == 0) a_first = smp;
            if (a_prev) a_falls++;
         end
         if (!nmi_b) begin
            b_low++;
            if (b_first == 0) b_first = smp;
            if (b_prev) b_falls++;
         end
         a_prev = nmi_a;
         b_prev = nmi_b;
      end
   end

   task automatic mon_clear();
      smp = 0;
      a_low = 0; a_first = 0; a_falls = 0; a_prev = nmi_a;
      b_low = 0; b_first = 0; b_falls = 0; b_prev = nmi_b;
      mon_on = 1'b1;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic settle();
      below = 1'b0;
      step(Q + P + 6);
   endtask

   task automatic check_both(input string req, input int falls, input int first, input int low_a,
                             input int low_b);
      check(req, "absorb falls", a_falls, falls);
      check(req, "absorb first low sample", a_first, first);
      check(req, "absorb low cycles", a_low, low_a);
      check(req, "restart falls", b_falls, falls);
      check(req, "restart first low sample", b_first, first);
      check(req, "restart low cycles", b_low, low_b);
   endtask

   initial begin
      // R1: reset holds the output inactive even with a warning present.
      below = 1'b1;
      ok = 1'b1;
      step(3);
      @(negedge clk);
      check("R1", "nmi during reset", nmi_a, 1);
      check("R1", "nmi_rt during reset", nmi_b, 1);
      below = 1'b0;
      step(1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "nmi after release", nmi_a, 1);
      check("R1", "nmi_rt after release", nmi_b, 1);
      step(2);

      // R2/R3/R4/R5: sweep run length across the qualification boundary.
      for (int len = 1; len <= Q + 4; len++) begin
         mon_clear();
         below = 1'b1;
         step(len);
         below = 1'b0;
         step(Q + P + 6);
         if (len < Q) begin
            check_both("R3", 0, 0, 0, 0);
         end else begin
            check_both((len == Q) ? "R2" : "R4", 1, Q + 1, P, P);
         end
      end

      // R5: a warning held far past the pulse yields a single pulse.
      mon_clear();
      below = 1'b1;
      step(P * 3);
      check("R5", "absorb falls while held", a_falls, 1);
      check("R5", "restart falls while held", b_falls, 1);
      check("R5", "absorb low while held", a_low, P);
      settle();

      // R3: two short runs split by one low sample never qualify.
      mon_clear();
      below = 1'b1;
      step(Q - 1);
      below = 1'b0;
      step(1);
      below = 1'b1;
      step(Q - 1);
      below = 1'b0;
      step(Q + P + 6);
      check_both("R3", 0, 0, 0, 0);

      // R8: requalification while the pulse runs.
      mon_clear();
      below = 1'b1;
      step(Q);
      below = 1'b0;
      step(1);
      below = 1'b1;
      step(Q);
      below = 1'b0;
      step(Q + P * 2 + 6);
      check_both("R8", 1, Q + 1, P, Q + 1 + P);

      // R6: with supply-good low the warning is ignored.
      ok = 1'b0;
      mon_clear();
      below = 1'b1;
      step(Q + P + 10);
      check("R6", "absorb low with supply-good off", a_low, 0);
      check("R6", "restart low with supply-good off", b_low, 0);

      // R7: supply-good rises under a standing warning; count starts then.
      mon_clear();
      ok = 1'b1;
      step(Q + P + 6);
      check_both("R7", 1, Q + 1, P, P);
      settle();

      // R6/R7: supply-good drops mid-pulse, then returns with the warning held.
      mon_clear();
      below = 1'b1;
      step(Q + 2);
      ok = 1'b0;
      #1;
      check("R6", "nmi right after supply-good drop", nmi_a, 1);
      check("R6", "nmi_rt right after supply-good drop", nmi_b, 1);
      step(5);
      check("R6", "nmi held off", nmi_a, 1);
      check("R6", "absorb low before dropout", a_low, 2);
      mon_clear();
      ok = 1'b1;
      step(Q + P + 6);
      check_both("R7", 1, Q + 1, P, P);
      settle();

      mon_on = 1'b0;
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule